// File: doc/BRIEF.md
# Push-Pull PWM Output Steering Controller

This block turns a free-running period counter and a digital duty word into two gate-drive signals for a push-pull power stage. Each period produces at most one pulse, and a toggle stage hands successive pulses to output A and then to output B. The two switches therefore conduct half a cycle apart and never together. Each period starts with a programmable blanking interval that holds both outputs low. After that interval the pulse runs for the commanded number of clocks, limited to a fixed fraction of the period.

A current-limit input and a shutdown input can cut the pulse short at any time. A latch then keeps the output off until the next period begins, so an input that chatters cannot produce a second pulse. Shutdown does not stop the period counter. Because the toggle stage only advances after a period in which a pulse was actually issued, the first pulse after shutdown is released goes to the output that did not fire last. An external sync input, passed through a two-flop synchronizer, restarts the period on its rising edge. Several controllers can be locked to a common clock this way, provided each local period is set somewhat longer than the sync period.

Top module: `pp_pwm_steer`

## Requirements
- R1: Pulses alternate between the outputs, one output per issued pulse. The first pulse after reset appears on out_a.
- R2: out_a and out_b are never high together. Both are low for the first blank_len counts of every period. A pulse starts blank_len counts after the period start and is cut off at the period end.
- R3: The pulse width in clocks is min(duty, MAX_ON), where MAX_ON = PERIOD*MAX_PCT/100. With the defaults this is 45% of the period.
- R4: Once a pulse has ended within a period, no further pulse starts in that period, even if the terminating input is released.
- R5: When ilim is high, both outputs are low on the next clock. ilim held high gives zero width.
- R6: When shutdown is high, both outputs are low on the next clock. The period counter keeps running, so pulses resume at the same phase as before.
- R7: After shutdown is released, the next pulse goes to the output other than the one that pulsed last.
- R8: A duty of 0 issues no pulse, and the toggle does not advance in such a period.
- R9: A rising edge on sync_in, seen two clocks later through the synchronizer, restarts the period counter at zero.
- R10: A synchronous high rst clears the counter, the toggle and the latch, and drives both outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| duty | input | CW | Commanded pulse width in clocks |
| blank_len | input | CW | Blanking clocks at each period start |
| shutdown | input | 1 | Forces outputs off; counter keeps running |
| ilim | input | 1 | Current-limit terminate, active high |
| sync_in | input | 1 | External period restart (asynchronous) |
| out_a | output | 1 | Drive for the first switch |
| out_b | output | 1 | Drive for the second switch |

## Verification
The main function is exercised with several duty words: small, mid-range, exactly at the cap and above the cap, which tells linear width apart from clamped width. It is also exercised with zero, one and large blanking values; the large value shows that a pulse is shifted by blanking and then truncated at the period end. Each pattern is measured over two whole periods, so the high-clock counts and edge counts do not depend on where the measurement window starts. Sync is driven at a shorter period with a blanking value that gives a different truncated width than free running would, which shows that the period really restarts. Directed sequences cover a single-clock limit blip in the middle of a pulse, a shutdown that is released in the middle of a window, and a run of zero-duty periods, each followed by a check of which output fires next.

// File: rtl/pp_pwm_steer.sv
module pp_pwm_steer #(
  parameter int PERIOD  = 200,
  parameter int MAX_PCT = 45,
  parameter int CW      = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] duty,
  input  logic [CW-1:0] blank_len,
  input  logic          shutdown,
  input  logic          ilim,
  input  logic          sync_in,
  output logic          out_a,
  output logic          out_b
);

  localparam int            MAX_ON = PERIOD * MAX_PCT / 100;
  localparam logic [CW-1:0] LAST   = CW'(PERIOD - 1);
  localparam logic [CW-1:0] ON_CAP = CW'(MAX_ON);

  logic [2:0]    sync_q;
  logic [CW-1:0] cnt;
  logic          phase, issued, done;

  logic          sync_edge, wrap, in_win, on;
  logic [CW-1:0] on_len, offs;

  assign sync_edge = sync_q[1] & ~sync_q[2];
  assign wrap      = sync_edge | (cnt == LAST);
  assign on_len    = (duty > ON_CAP) ? ON_CAP : duty;
  assign offs      = cnt - blank_len;
  assign in_win    = (cnt >= blank_len) && (offs < on_len);
  assign on        = in_win & ~done & ~ilim & ~shutdown;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[1:0], sync_in};
  end

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (wrap) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      issued <= 1'b0;
      done   <= 1'b0;
    end else if (wrap) begin
      issued <= 1'b0;
      done   <= 1'b0;
    end else begin
      issued <= issued | on;
      done   <= done | (in_win & (ilim | shutdown)) | (issued & ~on);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                       phase <= 1'b0;
    else if (wrap & (issued | on)) phase <= ~phase;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_a <= 1'b0;
      out_b <= 1'b0;
    end else begin
      out_a <= on & ~phase;
      out_b <= on & phase;
    end
  end

  logic [CW:0] hi_len;
  logic        seen, last_a;

  always_ff @(posedge clk) begin
    if (rst)                 hi_len <= '0;
    else if (out_a | out_b)  hi_len <= hi_len + 1'b1;
    else                     hi_len <= '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen   <= 1'b0;
      last_a <= 1'b0;
    end else if (out_a) begin
      seen   <= 1'b1;
      last_a <= 1'b1;
    end else if (out_b) begin
      seen   <= 1'b1;
      last_a <= 1'b0;
    end
  end

  // R1
  alternate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_a) |-> !(seen && last_a));

  // R2
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(out_a && out_b));

  // R2
  blank_low_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt < blank_len) |=> (!out_a && !out_b));

  // R3
  max_on_chk: assert property (@(posedge clk) disable iff (rst)
    hi_len <= (CW+1)'(MAX_ON));

  // R5
  ilim_off_chk: assert property (@(posedge clk) disable iff (rst)
    ilim |=> (!out_a && !out_b));

  // R6
  sd_off_chk: assert property (@(posedge clk) disable iff (rst)
    shutdown |=> (!out_a && !out_b));

  // R6
  sd_run_chk: assert property (@(posedge clk) disable iff (rst)
    (shutdown && !wrap) |=> (cnt == CW'($past(cnt) + 1'b1)));

  // R9
  sync_restart_chk: assert property (@(posedge clk) disable iff (rst)
    sync_edge |=> (cnt == '0));

endmodule

// File: tb/pp_pwm_steer_test.sv
module pp_pwm_steer_test;
  localparam int P  = 40;
  localparam int CW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CW-1:0] duty = '0;
  logic [CW-1:0] blank_len = '0;
  logic shutdown = 1'b0, ilim = 1'b0, sync_in = 1'b0;
  logic out_a, out_b;

  pp_pwm_steer #(.PERIOD(P), .MAX_PCT(45), .CW(CW)) uut (
    .clk(clk), .rst(rst), .duty(duty), .blank_len(blank_len),
    .shutdown(shutdown), .ilim(ilim), .sync_in(sync_in),
    .out_a(out_a), .out_b(out_b));

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  int ha, hb, ra, rb, ov;

  localparam int NV = 9;
  localparam int VD[NV] = '{5, 1, 12, 18, 19, 30, 0, 18, 7};
  localparam int VB[NV] = '{4, 4, 4, 4, 4, 4, 4, 30, 0};
  localparam int VW[NV] = '{5, 1, 12, 18, 18, 18, 0, 10, 7};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(input int n);
    logic pa, pb;
    ha = 0; hb = 0; ra = 0; rb = 0; ov = 0;
    pa = out_a; pb = out_b;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (out_a) ha++;
      if (out_b) hb++;
      if (out_a && out_b) ov++;
      if (out_a && !pa) ra++;
      if (out_b && !pb) rb++;
      pa = out_a; pb = out_b;
    end
  endtask

  task automatic wait_rise(input int lim, output int who, output int t);
    logic qa, qb;
    qa = out_a; qb = out_b; who = -1; t = 0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (out_a && !qa) begin who = 0; t = cyc; break; end
      if (out_b && !qb) begin who = 1; t = cyc; break; end
      qa = out_a; qb = out_b;
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    int who, t0, t1, x, y;
    duty = 6'd10; blank_len = 6'd4;
    repeat (5) @(negedge clk);
    // R10 reset state
    check(!out_a && !out_b, "R10 outputs low in reset", {out_a, out_b}, 0);
    rst = 1'b0;
    wait_rise(100, who, t0);
    check(who == 0, "R1 R10 first pulse on out_a", who, 0);

    for (int k = 0; k < NV; k++) begin
      duty = CW'(VD[k]); blank_len = CW'(VB[k]);
      repeat (3 * P) @(negedge clk);
      measure(2 * P);
      check(ha == VW[k], "R3 out_a width", ha, VW[k]);
      check(hb == VW[k], "R3 out_b width", hb, VW[k]);
      check(ra == (VW[k] > 0), "R1 R8 out_a one pulse", ra, int'(VW[k] > 0));
      check(rb == (VW[k] > 0), "R1 R8 out_b one pulse", rb, int'(VW[k] > 0));
      check(ov == 0, "R2 no overlap", ov, 0);
    end

    // R9 sync restarts the period: blank 30 gives width 6 at a 36-clock period
    duty = 6'd18; blank_len = 6'd30;
    fork
      begin
        for (int s = 0; s < 8; s++) begin
          sync_in = 1'b1;
          repeat (2) @(negedge clk);
          sync_in = 1'b0;
          repeat (34) @(negedge clk);
        end
      end
      begin
        repeat (4 * 36) @(negedge clk);
        measure(72);
        check(ha == 6, "R9 synced out_a width", ha, 6);
        check(hb == 6, "R9 synced out_b width", hb, 6);
        check(ra == 1 && rb == 1, "R9 one pulse each per synced pair", ra + rb, 2);
      end
    join

    // R4 R5 limit blip inside a pulse
    blank_len = 6'd4; duty = 6'd18;
    repeat (3 * P) @(negedge clk);
    who = 1;
    for (int i = 0; i < 3 && who != 0; i++) wait_rise(2 * P, who, t0);
    check(who == 0, "R1 locate out_a pulse", who, 0);
    repeat (2) @(negedge clk);
    ilim = 1'b1;
    @(negedge clk);
    check(!out_a && !out_b, "R5 limit cuts pulse", {out_a, out_b}, 0);
    ilim = 1'b0;
    measure(28);
    check(ha == 0 && hb == 0, "R4 no restart after limit release", ha + hb, 0);
    wait_rise(2 * P, who, t0);
    check(who == 1, "R1 next pulse on out_b", who, 1);

    // R6 R7 shutdown released mid-window
    wait_rise(2 * P, x, t0);
    repeat (3) @(negedge clk);
    shutdown = 1'b1;
    @(negedge clk);
    check(!out_a && !out_b, "R6 shutdown forces low", {out_a, out_b}, 0);
    measure(126);
    check(ha + hb == 0, "R6 held low during shutdown", ha + hb, 0);
    shutdown = 1'b0;
    wait_rise(3 * P, y, t1);
    check(y == 1 - x, "R7 no double pulse after release", y, 1 - x);
    check(((t1 - t0) % P) == 0, "R6 counter kept running", (t1 - t0) % P, 0);

    // R8 zero duty does not advance the toggle
    repeat (3) @(negedge clk);
    duty = '0;
    measure(3 * P);
    check(ha + hb == 0, "R8 zero duty gives no pulse", ha + hb, 0);
    duty = 6'd10;
    wait_rise(3 * P, who, t0);
    check(who == 1 - y, "R8 toggle held across zero duty", who, 1 - y);

    // R10 reset mid-run
    wait_rise(3 * P, who, t0);
    rst = 1'b1;
    @(negedge clk);
    check(!out_a && !out_b, "R10 reset drives outputs low", {out_a, out_b}, 0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    wait_rise(2 * P, who, t0);
    check(who == 0, "R10 toggle cleared to out_a", who, 0);

    finish_run();
  end
endmodule